// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is the target side of a two-wire serial bus, placed in front of a byte-wide memory held in an internal register array. A fast system clock oversamples the bus clock and data lines. Bus conditions and bit timing are recovered from those samples, and the data line is pulled low through an open-drain enable output. The block answers only when the select byte carries a fixed prefix and the values on three hardwired pins. A host then loads a two-byte word address and either streams data into a 32-byte page buffer or reads the array sequentially.

The buffered bytes are written into the array when the host closes the write with a stop. After that the block holds a busy window of programmable length. During the window it ignores its select byte, so a host can poll for completion by retrying the select. A write-protect input, taken at the stop, keeps the array from changing. With the default `ADDR_W = 11` the array is 2048 bytes (64 pages). Setting `ADDR_W = 13` gives the full 8192-byte size with 256 pages.

Top module: `tws_eeprom`

## Requirements
- R1: A start (data falling while the clock is high) begins a new command at any point and discards any byte in progress. A stop (data rising while the clock is high) returns the block to idle with the data line released.
- R2: The select byte is prefix 1010 in bits 7:4, the pin values in bits 3:1 and the direction in bit 0 (1 = read). A select that does not match is not acknowledged, and the line stays released until the next start.
- R3: Bits are captured on the rising bus clock, MSB first. The target drives each of its own bits, and its acknowledge, only after a falling bus clock. Each accepted byte is acknowledged by holding the line low through the ninth clock.
- R4: The word address is two bytes, high byte first. Only the low ADDR_W bits are kept and the upper bits are ignored.
- R5: Written bytes fill the page buffer at successive offsets. The 5-bit offset wraps inside the page, and a later byte at the same offset replaces the earlier one.
- R6: Only offsets that received a byte are written, and every other array location keeps its value.
- R7: With the write-protect input high at the stop, the array does not change and no busy window starts. The data bytes are still acknowledged.
- R8: A stop that commits a write starts a busy window of BUSY_CYCLES system clocks. During the window a matching select is not acknowledged, and after it the select is acknowledged again.
- R9: A write select plus a word address, then a repeated start and a read select, returns the byte at that address. A read select without an address returns the byte at the current address counter.
- R10: Every transmitted byte advances the full address counter, which wraps from the last location to 0. A host acknowledge continues the read. A host non-acknowledge ends it and leaves the line released.
- R11: A repeated start after write data, with no stop, discards the buffered bytes, so no array change and no busy window follow.
- R12: After reset the block is idle and not busy, the line is released, the address counter is 0 and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level as seen on the wire |
| addr_pins_i | input | 3 | Hardwired select value compared with select bits 3:1 |
| wp_i | input | 1 | Write protect, high blocks array writes |
| sda_oe_o | output | 1 | High pulls the data line low (open-drain enable) |

## Verification
The assertions watch, on every cycle, that the open-drain enable only moves after a recovered falling clock or a bus condition, and that it stays off in idle. They also check that no select is acknowledged while busy, that a protected stop never opens a busy window, that the window never exceeds its length, and that a stop always lands in idle. Array contents can only be shown by the bench's scenarios. These cover partial and wrapping pages, protected writes, aborted writes, address truncation, read rollover at the array's end, and the address counter after a single read.

// File: rtl/tws_pkg.sv
package tws_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WR,
        ST_RD
    } tws_state_t;

    localparam logic [3:0] SEL_PREFIX = 4'b1010;
    localparam int unsigned BYTE_BITS = 8;

    function automatic logic sel_match(input logic [7:0] b, input logic [2:0] pins);
        return (b[7:4] == SEL_PREFIX) && (b[3:1] == pins);
    endfunction

endpackage

// File: rtl/tws_line_monitor.sv
module tws_line_monitor #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
    logic scl_prev, sda_prev, scl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sr   <= '1;
            sda_sr   <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sr   <= {scl_sr[SYNC_STAGES-2:0], scl_i};
            sda_sr   <= {sda_sr[SYNC_STAGES-2:0], sda_i};
            scl_prev <= scl_q;
            sda_prev <= sda_q;
        end
    end

    assign scl_q     = scl_sr[SYNC_STAGES-1];
    assign sda_q     = sda_sr[SYNC_STAGES-1];
    assign scl_rise  = scl_q & ~scl_prev;
    assign scl_fall  = ~scl_q & scl_prev;
    assign start_det = scl_q & scl_prev & sda_prev & ~sda_q;
    assign stop_det  = scl_q & scl_prev & ~sda_prev & sda_q;
endmodule

// File: rtl/tws_busy_timer.sv
module tws_busy_timer #(
    parameter int BUSY_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    output logic busy
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);
    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)                remain <= '0;
        else if (kick)          remain <= CW'(BUSY_CYCLES);
        else if (remain != '0)  remain <= remain - CW'(1);
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/tws_page_store.sv
module tws_page_store #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     buf_we,
    input  logic [PAGE_W-1:0]        buf_idx,
    input  logic [7:0]               buf_din,
    input  logic                     buf_clear,
    input  logic                     commit,
    input  logic [ADDR_W-PAGE_W-1:0] commit_row,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rdata,
    output logic                     has_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int SLOTS = 1 << PAGE_W;

    logic [7:0]       mem  [DEPTH];
    logic [7:0]       pbuf [SLOTS];
    logic [SLOTS-1:0] filled;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= 8'hFF;
            filled <= '0;
        end else begin
            if (commit) begin
                for (int i = 0; i < SLOTS; i++)
                    if (filled[i]) mem[{commit_row, PAGE_W'(i)}] <= pbuf[i];
            end
            if (buf_clear || commit) begin
                filled <= '0;
            end else if (buf_we) begin
                pbuf[buf_idx]   <= buf_din;
                filled[buf_idx] <= 1'b1;
            end
        end
    end

    assign rdata    = mem[rd_addr];
    assign has_data = |filled;
endmodule

// File: rtl/tws_eeprom.sv
module tws_eeprom
    import tws_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 5,
    parameter int BUSY_CYCLES = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] addr_pins_i,
    input  logic       wp_i,
    output logic       sda_oe_o
);
    localparam int ROW_W = ADDR_W - PAGE_W;

    logic sda_q, scl_rise, scl_fall, start_det, stop_det;
    logic busy, commit, buf_we, has_data, sel_ok;
    logic [7:0] rdata, tx_view, shreg, addr_hi;
    logic [3:0] bitcnt;
    logic [ADDR_W-1:0] addr;
    tws_state_t st, nxt;

    tws_line_monitor #(.SYNC_STAGES(SYNC_STAGES)) mon_i (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    tws_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) busy_i (
        .clk(clk), .rst(rst), .kick(commit), .busy(busy)
    );

    tws_page_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) store_i (
        .clk(clk), .rst(rst),
        .buf_we(buf_we), .buf_idx(addr[PAGE_W-1:0]), .buf_din(shreg),
        .buf_clear(start_det | stop_det), .commit(commit),
        .commit_row(addr[ADDR_W-1:PAGE_W]), .rd_addr(addr),
        .rdata(rdata), .has_data(has_data)
    );

    assign sel_ok  = sel_match(shreg, addr_pins_i) && !busy;
    assign tx_view = rdata << bitcnt[2:0];
    assign buf_we  = scl_fall && (bitcnt == 4'd8) && (st == ST_WR) && !start_det && !stop_det;
    assign commit  = stop_det && (st == ST_WR) && has_data && !wp_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            nxt      <= ST_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            addr_hi  <= '0;
            addr     <= '0;
            sda_oe_o <= 1'b0;
        end else if (start_det) begin
            st       <= ST_DEV;
            bitcnt   <= '0;
            sda_oe_o <= 1'b0;
        end else if (stop_det) begin
            st       <= ST_IDLE;
            bitcnt   <= '0;
            sda_oe_o <= 1'b0;
        end else if (st != ST_IDLE) begin
            if (scl_rise) begin
                if (bitcnt != 4'd9) bitcnt <= bitcnt + 4'd1;
                if (bitcnt < 4'd8)  shreg  <= {shreg[6:0], sda_q};
                if (st == ST_RD && bitcnt == 4'd8) nxt <= sda_q ? ST_IDLE : ST_RD;
            end
            if (scl_fall) begin
                if (bitcnt == 4'd9) begin
                    bitcnt   <= '0;
                    st       <= nxt;
                    sda_oe_o <= (nxt == ST_RD) ? ~rdata[7] : 1'b0;
                end else if (st == ST_RD) begin
                    if (bitcnt == 4'd8) begin
                        sda_oe_o <= 1'b0;
                        addr     <= addr + ADDR_W'(1);
                    end else if (bitcnt != 4'd0) begin
                        sda_oe_o <= ~tx_view[7];
                    end
                end else if (bitcnt == 4'd8) begin
                    unique case (st)
                        ST_DEV: begin
                            sda_oe_o <= sel_ok;
                            nxt      <= !sel_ok ? ST_IDLE : (shreg[0] ? ST_RD : ST_AHI);
                        end
                        ST_AHI: begin
                            sda_oe_o <= 1'b1;
                            addr_hi  <= shreg;
                            nxt      <= ST_ALO;
                        end
                        ST_ALO: begin
                            sda_oe_o <= 1'b1;
                            addr     <= ADDR_W'({addr_hi, shreg});
                            nxt      <= ST_WR;
                        end
                        ST_WR: begin
                            sda_oe_o <= 1'b1;
                            addr     <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + PAGE_W'(1)};
                            nxt      <= ST_WR;
                        end
                        default: nxt <= ST_IDLE;
                    endcase
                end
            end
        end
    end

    logic [ROW_W-1:0] unused_row;
    assign unused_row = addr[ADDR_W-1:PAGE_W];
endmodule

// File: rtl/tws_eeprom_chk.sv
module tws_eeprom_chk
    import tws_pkg::*;
#(
    parameter int BUSY_CYCLES = 2000
) (
    input logic       clk,
    input logic       rst,
    input logic       sda_oe_o,
    input logic       wp_i,
    input logic       busy,
    input logic       scl_fall,
    input logic       start_det,
    input logic       stop_det,
    input tws_state_t st
);
    int busy_run;

    always_ff @(posedge clk) begin
        if (rst || !busy) busy_run <= 0;
        else              busy_run <= busy_run + 1;
    end

    // R3
    oe_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (sda_oe_o != $past(sda_oe_o)) |-> $past(scl_fall || start_det || stop_det));

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_oe_o);

    // R1
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (st == ST_IDLE));

    // R8
    busy_nack_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && st == ST_DEV) |-> !sda_oe_o);

    // R7
    wp_no_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(wp_i));

    // R8
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        busy_run <= BUSY_CYCLES);
endmodule

bind tws_eeprom tws_eeprom_chk #(.BUSY_CYCLES(BUSY_CYCLES)) chk_i (
    .clk(clk), .rst(rst), .sda_oe_o(sda_oe_o), .wp_i(wp_i), .busy(busy),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det), .st(st)
);

// File: tb/tws_eeprom_tb.sv
module tws_eeprom_tb_top;
    localparam int BUSY = 2000;
    localparam int H    = 10;
    localparam logic [2:0] PINS = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, PINS, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, PINS, 1'b1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
    logic sda_oe;
    wire  sda_line = m_sda & ~sda_oe;
    int n_chk = 0, n_err = 0;

    always #10 clk = ~clk;

    tws_eeprom #(.BUSY_CYCLES(BUSY)) dut_i (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
        .addr_pins_i(PINS), .wp_i(wp), .sda_oe_o(sda_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(H); m_scl = 1'b1; tick(H);
        m_sda = 1'b0; tick(H); m_scl = 1'b0; tick(H);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(H); m_scl = 1'b1; tick(H); m_sda = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(H); m_scl = 1'b1; tick(H); m_scl = 1'b0; tick(4);
        end
        m_sda = 1'b1; tick(H); m_scl = 1'b1; tick(H / 2);
        ack = !sda_line;
        tick(H / 2); m_scl = 1'b0; tick(4);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic last);
        m_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(H); m_scl = 1'b1; tick(H / 2);
            b = {b[6:0], sda_line};
            tick(H / 2); m_scl = 1'b0; tick(4);
        end
        m_sda = last; tick(H); m_scl = 1'b1; tick(H); m_scl = 1'b0; tick(4);
        m_sda = 1'b1;
    endtask

    task automatic addr_phase(input string req, input logic [15:0] wa);
        logic a;
        bus_start();
        send_byte(DEV_W, a);     check(req, "select ack", a, 1);
        send_byte(wa[15:8], a);  check(req, "addr hi ack", a, 1);
        send_byte(wa[7:0], a);   check(req, "addr lo ack", a, 1);
    endtask

    task automatic write_bytes(input string req, input logic [15:0] wa,
                               input int n, input logic [31:0] d);
        logic a;
        addr_phase(req, wa);
        for (int i = 0; i < n; i++) begin
            send_byte(d[31 - 8 * i -: 8], a);
            check(req, "data ack", a, 1);
        end
        bus_stop();
    endtask

    task automatic read_check(input string req, input logic [15:0] wa,
                              input int n, input logic [31:0] exp);
        logic a;
        logic [7:0] b;
        addr_phase(req, wa);
        bus_start();
        send_byte(DEV_R, a); check(req, "read select ack", a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(b, i == n - 1);
            check(req, "read data", b, exp[31 - 8 * i -: 8]);
        end
        bus_stop();
    endtask

    task automatic probe_select(input string req, input logic [7:0] sel, input logic exp);
        logic a;
        bus_start(); send_byte(sel, a); bus_stop();
        check(req, "select probe", a, exp);
    endtask

    task automatic t_reset();
        logic a;
        logic [7:0] b;
        check("R12", "line after reset", sda_oe, 0);
        bus_start();
        send_byte(DEV_R, a); check("R12", "select ack after reset", a, 1);
        recv_byte(b, 1'b1);  check("R12", "byte at address 0", b, 8'hFF);
        bus_stop();
        check("R1", "line after stop", sda_oe, 0);
    endtask

    task automatic t_select();
        probe_select("R2", {4'b1010, 3'b000, 1'b0}, 1'b0);
        check("R2", "line released after foreign select", sda_oe, 0);
        probe_select("R2", {4'b1011, PINS, 1'b0}, 1'b0);
        probe_select("R2", DEV_W, 1'b1);
    endtask

    task automatic t_page_write();
        write_bytes("R3", 16'h0123, 4, 32'h11223344);
        probe_select("R8", DEV_W, 1'b0);
        tick(BUSY + 100);
        probe_select("R8", DEV_W, 1'b1);
        read_check("R9", 16'h0123, 4, 32'h11223344);
        read_check("R6", 16'h0122, 1, 32'hFF000000);
        read_check("R6", 16'h0127, 1, 32'hFF000000);
        read_check("R4", 16'hF923, 1, 32'h11000000);
    endtask

    task automatic t_page_wrap();
        write_bytes("R5", 16'h005E, 4, 32'hA1A2A3A4);
        tick(BUSY + 100);
        read_check("R5", 16'h005E, 2, 32'hA1A20000);
        read_check("R5", 16'h0040, 2, 32'hA3A40000);
        read_check("R5", 16'h0060, 1, 32'hFF000000);
    endtask

    task automatic t_wp();
        wp = 1'b1;
        write_bytes("R7", 16'h0200, 1, 32'h5A000000);
        probe_select("R7", DEV_W, 1'b1);
        wp = 1'b0;
        read_check("R7", 16'h0200, 1, 32'hFF000000);
    endtask

    task automatic t_abort();
        logic a;
        addr_phase("R11", 16'h0300);
        send_byte(8'h77, a); check("R11", "data ack", a, 1);
        bus_start();
        send_byte(DEV_W, a); check("R11", "select ack without busy", a, 1);
        bus_stop();
        read_check("R11", 16'h0300, 1, 32'hFF000000);
    endtask

    task automatic t_rollover();
        write_bytes("R10", 16'h0000, 1, 32'h5C000000);
        tick(BUSY + 100);
        write_bytes("R10", 16'h07FE, 2, 32'hC1C20000);
        tick(BUSY + 100);
        read_check("R10", 16'h07FE, 3, 32'hC1C25C00);
    endtask

    task automatic t_current_addr();
        logic a;
        logic [7:0] b;
        read_check("R9", 16'h0123, 1, 32'h11000000);
        bus_start();
        send_byte(DEV_R, a); check("R10", "current read select ack", a, 1);
        recv_byte(b, 1'b1);  check("R10", "counter advanced after read", b, 8'h22);
        check("R10", "line released after host nack", sda_oe, 0);
        bus_stop();
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(5);
        t_reset();
        t_select();
        t_page_write();
        t_page_wrap();
        t_wp();
        t_abort();
        t_rollover();
        t_current_addr();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule